// File: doc/BRIEF.md
# Call-Gate Privilege Transition Sequencer

This block is a multi-cycle controller that carries out a protected far call through a gate descriptor, and the far return that undoes it. A caller presents a 64-bit gate descriptor together with the current code selector, instruction pointer, stack selector and stack pointer. The controller checks the gate and works out the target ring. It then runs the stack sequence through a single word-wide memory port and presents the resulting CS, IP, SS and SP.

When the call moves inward to a more privileged ring, the controller switches stacks. It fetches the target ring's stack pointer pair from a task-state table, saves the caller's stack pointer pair on the new stack, and copies the parameter words the gate asks for. It then saves the return address. When the target ring is not more privileged, only the return address is pushed on the current stack. A far return pops the return address, discards a given number of parameter bytes, and pops the outer stack pointer pair when it returns to a less privileged ring.

Memory addresses are a segment value plus a byte offset, and read data is taken in the same cycle as the address. Selector lookup, limit checks, task switching and instruction decoding belong to the surrounding logic.

Top module: `call_gate_seq`

## Requirements
- R1: After reset, busy, done, fault, mem_re and mem_we are all 0, and no memory access happens while busy is 0.
- R2: The descriptor is decoded as follows. Offset bits 15:0 come from descriptor bits 15:0 and offset bits 31:16 from bits 63:48. The code selector is bits 31:16, the parameter word count is bits 36:32, the type is bits 43:40, the gate privilege (DPL) is bits 46:45 and the present flag is bit 47. An accepted call yields new_cs equal to the selector and new_ip equal to offset bits 15:0.
- R3: Type 4 (16-bit gate) and type 12 (32-bit gate) are accepted. Any other type faults. A type-12 gate whose offset bits 31:16 are nonzero also faults, because the instruction pointer is 16 bits wide.
- R4: A faulting request sets fault together with done, writes no memory, and returns new_cs/new_ip/new_ss/new_sp equal to the current values.
- R5: The current privilege level is cur_cs[1:0]. A call faults when that level is numerically greater than the gate DPL.
- R6: When the target ring (selector bits 1:0) is numerically lower than the current level, the new stack pointer is read at byte offset 2+4*ring and the new stack selector at byte offset 4+4*ring, both in segment tss_seg.
- R7: On a stack-switching call the pushes go in this order: old SS, old SP, the parameter words, old CS, then old IP. Each push decrements SP by 2 before it writes, so the final SP is the table SP minus 2*(count+4).
- R8: Parameter words keep their order. Word k above the new stack's saved CS equals the word at old SP + 2k.
- R9: When the target ring is not more privileged, the table is not read, only old CS and then old IP are pushed on the current stack, SS is unchanged and SP drops by 4.
- R10: busy is 1 in every cycle after a request is accepted until done. done is a one-cycle pulse with busy at 0.
- R11: A return pops IP from SS:SP and then CS from SP+2, and adds ret_bytes to SP. When the popped CS has a less privileged level than the current one, it then pops SP and then SS, and these become new_sp and new_ss.
- R12: A return whose popped CS level equals the current level keeps SS and yields SP = old SP + 4 + ret_bytes. A return whose popped level is more privileged faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| call_req | input | 1 | Start a gate call (sampled while idle) |
| ret_req | input | 1 | Start a far return (sampled while idle, call wins) |
| gate_desc | input | 64 | Gate descriptor |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 16 | Current instruction pointer |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 16 | Current stack pointer |
| ret_bytes | input | 16 | Parameter bytes discarded on return |
| tss_seg | input | 16 | Segment holding the task-state table |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_seg | output | 16 | Segment of the access |
| mem_off | output | 16 | Byte offset of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle of mem_re |
| new_cs | output | 16 | Resulting code selector |
| new_ip | output | 16 | Resulting instruction pointer |
| new_ss | output | 16 | Resulting stack selector |
| new_sp | output | 16 | Resulting stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last request faulted |

## Verification
The hardest case to reach from the ports is a stack-switching call that also copies parameters. Here the reads from the old stack interleave with writes to the new stack, and the ring index must pick the right pair of table words. The bench preloads distinct table entries for rings 0, 1 and 2 and distinct parameter words on the old stack. It issues calls with counts of 0, 1 and 2 so that each ring entry and each copy length is used. It then feeds the frame it built back into a return, so the pops read exactly what the pushes stored.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

    localparam int WORD_W = 16;
    localparam int DESC_W = 64;
    localparam int PCNT_W = 5;

    localparam logic [3:0] GATE_T16 = 4'h4;
    localparam logic [3:0] GATE_T32 = 4'hC;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TSS_SP,
        ST_TSS_SS,
        ST_PUSH_SS,
        ST_PUSH_SP,
        ST_PRM_RD,
        ST_PRM_WR,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_SP,
        ST_POP_SS,
        ST_FIN
    } cgs_state_e;

    typedef struct packed {
        logic [WORD_W-1:0]   sel;
        logic [2*WORD_W-1:0] offset;
        logic [PCNT_W-1:0]   pcnt;
        logic [3:0]          gtype;
        logic [1:0]          dpl;
        logic                present;
    } gate_fields_t;

endpackage

// File: rtl/cgs_gate_check.sv
module cgs_gate_check
    import cgs_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [WORD_W-1:0] cs_now,
    output gate_fields_t      fld,
    output logic              bad,
    output logic              inward
);
    logic [1:0] cpl;
    logic       type_ok;
    logic       wide_ip;

    always_comb begin
        fld.offset  = {desc[63:48], desc[15:0]};
        fld.sel     = desc[31:16];
        fld.pcnt    = desc[32 +: PCNT_W];
        fld.gtype   = desc[43:40];
        fld.dpl     = desc[46:45];
        fld.present = desc[47];

        cpl     = cs_now[1:0];
        type_ok = (fld.gtype == GATE_T16) || (fld.gtype == GATE_T32);
        wide_ip = (fld.gtype == GATE_T32) && (fld.offset[2*WORD_W-1:WORD_W] != '0);
        bad     = !fld.present || !type_ok || wide_ip || (cpl > fld.dpl);
        inward  = fld.sel[1:0] < cpl;
    end
endmodule

// File: rtl/cgs_tss_locate.sv
module cgs_tss_locate
    import cgs_pkg::*;
#(
    parameter int TSS_BASE   = 2,
    parameter int TSS_STRIDE = 4,
    parameter int RINGS      = 3
) (
    input  logic [1:0]        ring,
    output logic [WORD_W-1:0] sp_off,
    output logic [WORD_W-1:0] ss_off
);
    localparam int SS_GAP = 2;

    logic [WORD_W-1:0] sp_tbl [RINGS];

    for (genvar r = 0; r < RINGS; r++) begin : g_ring
        assign sp_tbl[r] = WORD_W'(TSS_BASE + TSS_STRIDE * r);
    end

    always_comb begin
        sp_off = '0;
        for (int r = 0; r < RINGS; r++) begin
            if (int'(ring) == r) sp_off = sp_tbl[r];
        end
        ss_off = sp_off + WORD_W'(SS_GAP);
    end
endmodule

// File: rtl/call_gate_seq.sv
module call_gate_seq
    import cgs_pkg::*;
#(
    parameter int TSS_BASE   = 2,
    parameter int TSS_STRIDE = 4,
    parameter int RINGS      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [63:0]       gate_desc,
    input  logic [15:0]       cur_cs,
    input  logic [15:0]       cur_ip,
    input  logic [15:0]       cur_ss,
    input  logic [15:0]       cur_sp,
    input  logic [15:0]       ret_bytes,
    input  logic [15:0]       tss_seg,
    output logic              mem_re,
    output logic              mem_we,
    output logic [15:0]       mem_seg,
    output logic [15:0]       mem_off,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic [15:0]       new_cs,
    output logic [15:0]       new_ip,
    output logic [15:0]       new_ss,
    output logic [15:0]       new_sp,
    output logic              busy,
    output logic              done,
    output logic              fault
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

    typedef struct packed {
        cgs_state_e        st;
        logic [WORD_W-1:0] res_cs, res_ip, res_ss, res_sp;
        logic [WORD_W-1:0] old_cs, old_ip, old_ss, old_sp;
        logic [WORD_W-1:0] stk_ss, stk_sp;
        logic [WORD_W-1:0] tgt_cs, tgt_ip;
        logic [WORD_W-1:0] ret_n;
        logic [WORD_W-1:0] prm;
        logic [WORD_W-1:0] pop_ip, pop_cs, pop_sp;
        logic [1:0]        ring;
        logic [PCNT_W-1:0] pcnt, idx;
        logic              fault;
    } seq_regs_t;

    seq_regs_t    q, d;
    gate_fields_t fld;
    logic         gate_bad, gate_inward;
    logic [WORD_W-1:0] tss_sp_off, tss_ss_off;
    logic [WORD_W-1:0] sp_after;

    cgs_gate_check u_check (
        .desc   (gate_desc),
        .cs_now (cur_cs),
        .fld    (fld),
        .bad    (gate_bad),
        .inward (gate_inward)
    );

    cgs_tss_locate #(
        .TSS_BASE   (TSS_BASE),
        .TSS_STRIDE (TSS_STRIDE),
        .RINGS      (RINGS)
    ) u_tss (
        .ring   (q.ring),
        .sp_off (tss_sp_off),
        .ss_off (tss_ss_off)
    );

    always_comb begin
        d         = q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_seg   = q.stk_ss;
        mem_off   = q.stk_sp;
        mem_wdata = '0;
        sp_after  = q.stk_sp + STEP + q.ret_n;

        unique case (q.st)
            ST_IDLE: begin
                if (call_req || ret_req) begin
                    d.old_cs = cur_cs;
                    d.old_ip = cur_ip;
                    d.old_ss = cur_ss;
                    d.old_sp = cur_sp;
                    d.res_cs = cur_cs;
                    d.res_ip = cur_ip;
                    d.res_ss = cur_ss;
                    d.res_sp = cur_sp;
                    d.stk_ss = cur_ss;
                    d.stk_sp = cur_sp;
                    d.fault  = 1'b0;
                end
                if (call_req) begin
                    d.tgt_cs = fld.sel;
                    d.tgt_ip = fld.offset[WORD_W-1:0];
                    d.pcnt   = fld.pcnt;
                    d.ring   = fld.sel[1:0];
                    if (gate_bad) begin
                        d.fault = 1'b1;
                        d.st    = ST_FIN;
                    end else if (gate_inward) begin
                        d.st = ST_TSS_SP;
                    end else begin
                        d.st = ST_PUSH_CS;
                    end
                end else if (ret_req) begin
                    d.ret_n = ret_bytes;
                    d.st    = ST_POP_IP;
                end
            end
            ST_TSS_SP: begin
                mem_re   = 1'b1;
                mem_seg  = tss_seg;
                mem_off  = tss_sp_off;
                d.stk_sp = mem_rdata;
                d.st     = ST_TSS_SS;
            end
            ST_TSS_SS: begin
                mem_re   = 1'b1;
                mem_seg  = tss_seg;
                mem_off  = tss_ss_off;
                d.stk_ss = mem_rdata;
                d.st     = ST_PUSH_SS;
            end
            ST_PUSH_SS: begin
                mem_we    = 1'b1;
                mem_off   = q.stk_sp - STEP;
                mem_wdata = q.old_ss;
                d.stk_sp  = q.stk_sp - STEP;
                d.st      = ST_PUSH_SP;
            end
            ST_PUSH_SP: begin
                mem_we    = 1'b1;
                mem_off   = q.stk_sp - STEP;
                mem_wdata = q.old_sp;
                d.stk_sp  = q.stk_sp - STEP;
                if (q.pcnt != '0) begin
                    d.idx = q.pcnt - PCNT_W'(1);
                    d.st  = ST_PRM_RD;
                end else begin
                    d.st = ST_PUSH_CS;
                end
            end
            ST_PRM_RD: begin
                mem_re  = 1'b1;
                mem_seg = q.old_ss;
                mem_off = q.old_sp + WORD_W'({q.idx, 1'b0});
                d.prm   = mem_rdata;
                d.st    = ST_PRM_WR;
            end
            ST_PRM_WR: begin
                mem_we    = 1'b1;
                mem_off   = q.stk_sp - STEP;
                mem_wdata = q.prm;
                d.stk_sp  = q.stk_sp - STEP;
                if (q.idx == '0) begin
                    d.st = ST_PUSH_CS;
                end else begin
                    d.idx = q.idx - PCNT_W'(1);
                    d.st  = ST_PRM_RD;
                end
            end
            ST_PUSH_CS: begin
                mem_we    = 1'b1;
                mem_off   = q.stk_sp - STEP;
                mem_wdata = q.old_cs;
                d.stk_sp  = q.stk_sp - STEP;
                d.st      = ST_PUSH_IP;
            end
            ST_PUSH_IP: begin
                mem_we    = 1'b1;
                mem_off   = q.stk_sp - STEP;
                mem_wdata = q.old_ip;
                d.stk_sp  = q.stk_sp - STEP;
                d.res_cs  = q.tgt_cs;
                d.res_ip  = q.tgt_ip;
                d.res_ss  = q.stk_ss;
                d.res_sp  = q.stk_sp - STEP;
                d.st      = ST_FIN;
            end
            ST_POP_IP: begin
                mem_re   = 1'b1;
                d.pop_ip = mem_rdata;
                d.stk_sp = q.stk_sp + STEP;
                d.st     = ST_POP_CS;
            end
            ST_POP_CS: begin
                mem_re   = 1'b1;
                d.pop_cs = mem_rdata;
                if (mem_rdata[1:0] < q.old_cs[1:0]) begin
                    d.fault = 1'b1;
                    d.st    = ST_FIN;
                end else if (mem_rdata[1:0] == q.old_cs[1:0]) begin
                    d.res_cs = mem_rdata;
                    d.res_ip = q.pop_ip;
                    d.res_ss = q.old_ss;
                    d.res_sp = sp_after;
                    d.st     = ST_FIN;
                end else begin
                    d.stk_sp = sp_after;
                    d.st     = ST_POP_SP;
                end
            end
            ST_POP_SP: begin
                mem_re   = 1'b1;
                d.pop_sp = mem_rdata;
                d.stk_sp = q.stk_sp + STEP;
                d.st     = ST_POP_SS;
            end
            ST_POP_SS: begin
                mem_re   = 1'b1;
                d.res_cs = q.pop_cs;
                d.res_ip = q.pop_ip;
                d.res_sp = q.pop_sp;
                d.res_ss = mem_rdata;
                d.st     = ST_FIN;
            end
            ST_FIN: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.st != ST_IDLE) && (q.st != ST_FIN);
    assign done   = (q.st == ST_FIN);
    assign fault  = q.fault;
    assign new_cs = q.res_cs;
    assign new_ip = q.res_ip;
    assign new_ss = q.res_ss;
    assign new_sp = q.res_sp;
endmodule

// File: rtl/cgs_checker.sv
module cgs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic        mem_re,
    input logic        mem_we,
    input logic [15:0] mem_seg,
    input logic [15:0] mem_off,
    input logic [15:0] cur_cs,
    input logic [15:0] cur_ip,
    input logic [15:0] cur_ss,
    input logic [15:0] cur_sp,
    input logic [15:0] new_cs,
    input logic [15:0] new_ip,
    input logic [15:0] new_ss,
    input logic [15:0] new_sp
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_ends_in_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_fault_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (new_cs == cur_cs && new_ip == cur_ip &&
                             new_ss == cur_ss && new_sp == cur_sp));

    assert_fault_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> !$past(mem_we));

    assert_push_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_seg == $past(mem_seg) && mem_off == $past(mem_off) - 16'd2));
endmodule

bind call_gate_seq cgs_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .fault   (fault),
    .mem_re  (mem_re),
    .mem_we  (mem_we),
    .mem_seg (mem_seg),
    .mem_off (mem_off),
    .cur_cs  (cur_cs),
    .cur_ip  (cur_ip),
    .cur_ss  (cur_ss),
    .cur_sp  (cur_sp),
    .new_cs  (new_cs),
    .new_ip  (new_ip),
    .new_ss  (new_ss),
    .new_sp  (new_sp)
);

// File: tb/call_gate_seq_tb.sv
module call_gate_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0;
    logic        ret_req = 1'b0;
    logic [63:0] gate_desc = '0;
    logic [15:0] cur_cs = '0, cur_ip = '0, cur_ss = '0, cur_sp = '0;
    logic [15:0] ret_bytes = '0;
    logic [15:0] tss_seg = 16'd1;
    logic        mem_re, mem_we;
    logic [15:0] mem_seg, mem_off, mem_wdata, mem_rdata;
    logic [15:0] new_cs, new_ip, new_ss, new_sp;
    logic        busy, done, fault;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int cyc = 0;

    logic [15:0] mem [2048];

    always #5 clk = ~clk;

    function automatic int widx(input logic [15:0] seg, input logic [15:0] off);
        return int'({seg[2:0], off[8:1]});
    endfunction

    assign mem_rdata = mem[widx(mem_seg, mem_off)];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[widx(mem_seg, mem_off)] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re) rd_cnt <= rd_cnt + 1;
    end

    call_gate_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .gate_desc (gate_desc),
        .cur_cs    (cur_cs),
        .cur_ip    (cur_ip),
        .cur_ss    (cur_ss),
        .cur_sp    (cur_sp),
        .ret_bytes (ret_bytes),
        .tss_seg   (tss_seg),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_seg   (mem_seg),
        .mem_off   (mem_off),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .new_cs    (new_cs),
        .new_ip    (new_ip),
        .new_ss    (new_ss),
        .new_sp    (new_sp),
        .busy      (busy),
        .done      (done),
        .fault     (fault)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkdesc(input logic [15:0] sel, input logic [31:0] off,
                                           input logic [4:0] cnt, input logic [3:0] typ,
                                           input logic [1:0] dpl, input logic p);
        return {off[31:16], p, dpl, 1'b0, typ, 3'b000, cnt, sel, off[15:0]};
    endfunction

    function automatic logic [15:0] rd(input logic [15:0] seg, input logic [15:0] off);
        return mem[widx(seg, off)];
    endfunction

    task automatic set_cur(input logic [15:0] cs, ip, ss, sp);
        cur_cs = cs; cur_ip = ip; cur_ss = ss; cur_sp = sp;
    endtask

    // Issue one request, wait for done, check busy/done handshake (R10).
    task automatic run_op(input bit is_call, input string tag);
        int n = 0;
        bit busy_ok = 1'b1;
        @(negedge clk);
        call_req = is_call;
        ret_req  = !is_call;
        @(negedge clk);
        call_req = 1'b0;
        ret_req  = 1'b0;
        while (!done && n < 100) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        chk({tag, " R10 busy held until done"}, 16'(busy_ok), 16'd1);
        chk({tag, " R10 done with busy low"}, 16'({done, busy}), 16'b10);
    endtask

    task automatic after_done(input string tag);
        @(negedge clk);
        chk({tag, " R10 done lasts one cycle"}, 16'(done), 16'd0);
    endtask

    task automatic t_reset;
        chk("R1 busy after reset", 16'(busy), 16'd0);
        chk("R1 done after reset", 16'(done), 16'd0);
        chk("R1 fault after reset", 16'(fault), 16'd0);
        chk("R1 mem strobes after reset", 16'({mem_re, mem_we}), 16'd0);
    endtask

    // Ring 3 -> ring 0, two parameters.
    task automatic t_call_r0;
        mem[widx(5, 16'h00F0)] = 16'hAAAA;
        mem[widx(5, 16'h00F2)] = 16'hBBBB;
        set_cur(16'h001B, 16'h4444, 16'h0005, 16'h00F0);
        gate_desc = mkdesc(16'h0008, 32'h0000_1234, 5'd2, 4'h4, 2'd3, 1'b1);
        run_op(1'b1, "call r0");
        chk("R2 new_cs from selector", new_cs, 16'h0008);
        chk("R2 new_ip from offset", new_ip, 16'h1234);
        chk("R6 ring0 new_ss", new_ss, 16'h0002);
        chk("R7 ring0 final sp", new_sp, 16'h00F4);
        chk("R7 ring0 fault clear", 16'(fault), 16'd0);
        chk("R7 saved ip", rd(2, 16'h00F4), 16'h4444);
        chk("R7 saved cs", rd(2, 16'h00F6), 16'h001B);
        chk("R8 param word 0", rd(2, 16'h00F8), 16'hAAAA);
        chk("R8 param word 1", rd(2, 16'h00FA), 16'hBBBB);
        chk("R7 saved sp", rd(2, 16'h00FC), 16'h00F0);
        chk("R7 saved ss", rd(2, 16'h00FE), 16'h0005);
        after_done("call r0");
    endtask

    // Outward return from the frame built above, discarding 4 bytes.
    task automatic t_ret_outer;
        set_cur(16'h0008, 16'h1234, 16'h0002, 16'h00F4);
        ret_bytes = 16'd4;
        run_op(1'b0, "ret outer");
        chk("R11 restored cs", new_cs, 16'h001B);
        chk("R11 restored ip", new_ip, 16'h4444);
        chk("R11 restored ss", new_ss, 16'h0005);
        chk("R11 restored sp", new_sp, 16'h00F0);
        chk("R11 no fault", 16'(fault), 16'd0);
        after_done("ret outer");
    endtask

    // Ring 2 -> ring 1, no parameters.
    task automatic t_call_r1;
        set_cur(16'h0012, 16'h5151, 16'h0005, 16'h00E0);
        gate_desc = mkdesc(16'h0021, 32'h0000_2222, 5'd0, 4'h4, 2'd2, 1'b1);
        run_op(1'b1, "call r1");
        chk("R6 ring1 new_ss", new_ss, 16'h0003);
        chk("R7 ring1 final sp", new_sp, 16'h0178);
        chk("R7 ring1 saved ip", rd(3, 16'h0178), 16'h5151);
        chk("R7 ring1 saved cs", rd(3, 16'h017A), 16'h0012);
        chk("R7 ring1 saved sp", rd(3, 16'h017C), 16'h00E0);
        chk("R7 ring1 saved ss", rd(3, 16'h017E), 16'h0005);
        after_done("call r1");
    endtask

    // Ring 3 -> ring 2 through a 32-bit gate type with a zero high offset.
    task automatic t_call_r2_wide;
        mem[widx(5, 16'h00D0)] = 16'hC0DE;
        set_cur(16'h001B, 16'h6060, 16'h0005, 16'h00D0);
        gate_desc = mkdesc(16'h002A, 32'h0000_5678, 5'd1, 4'hC, 2'd3, 1'b1);
        run_op(1'b1, "call r2");
        chk("R3 type 12 accepted", 16'(fault), 16'd0);
        chk("R2 wide gate ip", new_ip, 16'h5678);
        chk("R6 ring2 new_ss", new_ss, 16'h0004);
        chk("R7 ring2 final sp", new_sp, 16'h01B6);
        chk("R8 single param", rd(4, 16'h01BA), 16'hC0DE);
        after_done("call r2");
    endtask

    // Same-ring call: no table read, only CS and IP pushed.
    task automatic t_call_same;
        int rd0;
        set_cur(16'h0008, 16'h7777, 16'h0006, 16'h0080);
        gate_desc = mkdesc(16'h0010, 32'h0000_3333, 5'd3, 4'h4, 2'd0, 1'b1);
        rd0 = rd_cnt;
        run_op(1'b1, "call same");
        chk("R9 no reads", 16'(rd_cnt - rd0), 16'd0);
        chk("R9 ss unchanged", new_ss, 16'h0006);
        chk("R9 sp minus 4", new_sp, 16'h007C);
        chk("R9 cs target", new_cs, 16'h0010);
        chk("R9 pushed ip", rd(6, 16'h007C), 16'h7777);
        chk("R9 pushed cs", rd(6, 16'h007E), 16'h0008);
        after_done("call same");
    endtask

    // Same-ring return, discarding 6 bytes.
    task automatic t_ret_same;
        set_cur(16'h0010, 16'h3333, 16'h0006, 16'h007C);
        ret_bytes = 16'd6;
        run_op(1'b0, "ret same");
        chk("R12 same cs", new_cs, 16'h0008);
        chk("R12 same ip", new_ip, 16'h7777);
        chk("R12 ss kept", new_ss, 16'h0006);
        chk("R12 sp adjusted", new_sp, 16'h0086);
        after_done("ret same");
    endtask

    // Return to a more privileged ring faults.
    task automatic t_ret_inward;
        mem[widx(6, 16'h0040)] = 16'h1111;
        mem[widx(6, 16'h0042)] = 16'h0008;
        set_cur(16'h001B, 16'h9999, 16'h0006, 16'h0040);
        ret_bytes = 16'd0;
        run_op(1'b0, "ret inward");
        chk("R12 inward return faults", 16'(fault), 16'd1);
        chk("R12 inward cs kept", new_cs, 16'h001B);
        chk("R12 inward sp kept", new_sp, 16'h0040);
        after_done("ret inward");
    endtask

    task automatic t_fault(input logic [63:0] desc, input logic [15:0] cs, input string tag);
        int w0;
        set_cur(cs, 16'hABCD, 16'h0005, 16'h00C0);
        gate_desc = desc;
        w0 = wr_cnt;
        run_op(1'b1, tag);
        chk({tag, " fault set"}, 16'(fault), 16'd1);
        chk({tag, " R4 no writes"}, 16'(wr_cnt - w0), 16'd0);
        chk({tag, " R4 cs kept"}, new_cs, cs);
        chk({tag, " R4 ip kept"}, new_ip, 16'hABCD);
        chk({tag, " R4 ss kept"}, new_ss, 16'h0005);
        chk({tag, " R4 sp kept"}, new_sp, 16'h00C0);
        after_done(tag);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
        mem[widx(1, 16'd2)]  = 16'h0100;
        mem[widx(1, 16'd4)]  = 16'h0002;
        mem[widx(1, 16'd6)]  = 16'h0180;
        mem[widx(1, 16'd8)]  = 16'h0003;
        mem[widx(1, 16'd10)] = 16'h01C0;
        mem[widx(1, 16'd12)] = 16'h0004;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_call_r0();
        t_ret_outer();
        t_call_r1();
        t_call_r2_wide();
        t_call_same();
        t_ret_same();
        t_ret_inward();
        t_fault(mkdesc(16'h0008, 32'h0000_1000, 5'd0, 4'h4, 2'd3, 1'b0), 16'h001B, "R4 not present");
        t_fault(mkdesc(16'h0008, 32'h0000_1000, 5'd0, 4'h5, 2'd3, 1'b1), 16'h001B, "R3 bad type");
        t_fault(mkdesc(16'h0008, 32'h0001_1000, 5'd0, 4'hC, 2'd3, 1'b1), 16'h001B, "R3 wide offset");
        t_fault(mkdesc(16'h0008, 32'h0000_1000, 5'd0, 4'h4, 2'd1, 1'b1), 16'h001B, "R5 cpl above dpl");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule